// File: doc/BRIEF.md
# Clock Group Rate-Change Sequencer

This block changes the frequency of a set of derived clocks that all hang off one PLL. A client asks for a group rate (an integer number of MHz). The block looks that rate up in a small constant table. The table gives the PLL frequency the group needs and one divider value for each derived output. The block then sequences two kinds of work: a request to a separate PLL reprogramming engine, and a run of divider-register writes on a simple address/data port.

The order of the two kinds of work is chosen so that no derived output ever runs faster than intended while the change is in flight. When the new PLL frequency is below the present one, the PLL is changed first and the dividers follow. Otherwise every divider is written first and the PLL is changed last. An unknown rate is refused outright: the block flags it and touches nothing.

The group is chosen by the parameter `GROUP_SEL`. Value 0 selects the main system group: four rates and sixteen dividers. Value 1 selects a smaller peripheral group: rates of 25 to 150 MHz in 25 MHz steps, three dividers at 0x380, 0x390 and 0x3A0, and a 600 MHz PLL except for a 700 MHz PLL at 125 MHz. The requirements below describe the default system group.

Top module: `clkgrp_rate_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err_rate`, `pll_fail`, `wr_en` and `pll_req` are all low.
- R2: The accepted group rates are 200, 400, 600 and 800 (MHz on `req_rate`). Their PLL targets are 800, 800, 600 and 800. `pll_rate` shows the target while `pll_req` is high.
- R3: A request whose rate matches no table entry makes `done` and `err_rate` high in the cycle after acceptance. It makes no divider write and never raises `pll_req`.
- R4: If the target is below `cur_pll_rate` as sampled at acceptance, `pll_req` rises in the cycle after acceptance. The first divider write appears in the cycle after `pll_ack` is sampled.
- R5: If the target is greater than or equal to `cur_pll_rate`, the first divider write appears in the cycle after acceptance. `pll_req` rises in the cycle after the last write.
- R6: A valid request makes exactly 16 divider writes, one in each of 16 consecutive cycles. Write k (k = 0..15) goes to address 0x180 + 0x10*k, in ascending order.
- R7: Write k carries the divider for output k in the column of the requested rate. For k = 1 the values are 4, 2, 1, 1 for 200, 400, 600 and 800. For every other k, take the base B = 4,-,2,2,2,2,1,2,4,2,4,8,24,4,24,16 (k = 0..15). The divider is B at 200, 400 and 800 MHz. At 600 MHz it is 3*B/4 when B is at least 4, and B otherwise.
- R8: `pll_req` stays high until `pll_ack` is sampled high, and is low in the next cycle.
- R9: For a valid request, `pll_fail` during the `done` cycle equals `pll_err` as sampled together with `pll_ack`, and `err_rate` is low.
- R10: `done` is a single-cycle pulse. It comes one cycle after the last step: the acknowledge in the post-write order, or the last write in the pre-write order. `busy` is high during the `done` cycle and low in the cycle after it.
- R11: `req_valid` pulses while `busy` is high are ignored; the running sequence completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a rate change (taken only while idle) |
| req_rate | input | RATE_W | Requested group rate in MHz |
| cur_pll_rate | input | RATE_W | Present PLL rate in MHz |
| busy | output | 1 | A sequence is in progress |
| pll_req | output | 1 | Request to the PLL reprogramming engine |
| pll_rate | output | RATE_W | Target PLL rate in MHz |
| pll_ack | input | 1 | PLL engine finished |
| pll_err | input | 1 | PLL engine failure, valid with pll_ack |
| wr_en | output | 1 | Divider write strobe |
| wr_addr | output | ADDR_W | Divider register address |
| wr_data | output | DIV_W | Divider value |
| done | output | 1 | Sequence finished (one cycle) |
| err_rate | output | 1 | Requested rate not in table, valid with done |
| pll_fail | output | 1 | PLL step reported failure, valid with done |

## Verification
The bench drives every table rate with a present PLL rate above, equal to and below the target. This separates the pre-write order from the post-write order, and the equal case pins the tie to the post-write side. Random requests add unlisted rates, values next to listed ones and zero; these show that a near miss is refused with no side effect. Random acknowledge delays and error flags separate the handshake timing from the write timing and show that the returned status follows the PLL step. One run sends a second request in the middle of a sequence and checks that the write stream and the target it produces are unaffected.

// File: rtl/clkgrp_pkg.sv
package clkgrp_pkg;

    localparam int GRP_SYSTEM = 0;
    localparam int GRP_TUNNEL = 1;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_PLL_PRE,
        SEQ_WRITE,
        SEQ_PLL_POST,
        SEQ_FIN
    } seq_st_e;

    function automatic int grp_nrates(input int sel);
        return (sel == GRP_TUNNEL) ? 6 : 4;
    endfunction

    function automatic int grp_ndiv(input int sel);
        return (sel == GRP_TUNNEL) ? 3 : 16;
    endfunction

    function automatic int grp_base(input int sel);
        return (sel == GRP_TUNNEL) ? 'h380 : 'h180;
    endfunction

    // group rate of column i, MHz
    function automatic int grp_rate(input int sel, input int i);
        return (sel == GRP_TUNNEL) ? 25 * (i + 1) : 200 * (i + 1);
    endfunction

    // PLL rate needed by column i, MHz
    function automatic int grp_pll(input int sel, input int i);
        if (sel == GRP_TUNNEL)
            return (i == 4) ? 700 : 600;
        return (i == 2) ? 600 : 800;
    endfunction

    // divider of output d in column i; columns packed MSB first
    function automatic int grp_div(input int sel, input int d, input int i);
        logic [47:0] row;
        row = '0;
        if (sel == GRP_TUNNEL) begin
            case (d)
                0:       row = {8'd24, 8'd12, 8'd8, 8'd6, 8'd6, 8'd4};
                1:       row = {8'd4,  8'd4,  8'd4, 8'd4, 8'd5, 8'd4};
                default: row = {8'd8,  8'd8,  8'd8, 8'd8, 8'd10, 8'd8};
            endcase
        end else begin
            case (d)
                0, 8, 10, 13: row = {8'd4,  8'd4,  8'd3,  8'd4,  16'd0};
                1:            row = {8'd4,  8'd2,  8'd1,  8'd1,  16'd0};
                6:            row = {8'd1,  8'd1,  8'd1,  8'd1,  16'd0};
                11:           row = {8'd8,  8'd8,  8'd6,  8'd8,  16'd0};
                12, 14:       row = {8'd24, 8'd24, 8'd18, 8'd24, 16'd0};
                15:           row = {8'd16, 8'd16, 8'd12, 8'd16, 16'd0};
                default:      row = {8'd2,  8'd2,  8'd2,  8'd2,  16'd0};
            endcase
        end
        return int'(row[47 - 8 * i -: 8]);
    endfunction

endpackage

// File: rtl/clkgrp_rate_match.sv
module clkgrp_rate_match
    import clkgrp_pkg::*;
#(
    parameter int GROUP_SEL = GRP_SYSTEM,
    parameter int RATE_W    = 12,
    parameter int RIDX_W    = 2
) (
    input  logic [RATE_W-1:0] req_rate,
    output logic              hit,
    output logic [RIDX_W-1:0] ridx,
    output logic [RATE_W-1:0] pll_tgt
);
    localparam int N_RATES = grp_nrates(GROUP_SEL);

    logic [N_RATES-1:0] eq;
    logic [RATE_W-1:0]  pll_tab [N_RATES];

    for (genvar g = 0; g < N_RATES; g++) begin : g_col
        assign eq[g]      = (req_rate == RATE_W'(grp_rate(GROUP_SEL, g)));
        assign pll_tab[g] = RATE_W'(grp_pll(GROUP_SEL, g));
    end

    always_comb begin
        hit     = |eq;
        ridx    = '0;
        pll_tgt = '0;
        for (int i = N_RATES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                ridx    = RIDX_W'(i);
                pll_tgt = pll_tab[i];
            end
        end
    end

endmodule

// File: rtl/clkgrp_div_rom.sv
module clkgrp_div_rom
    import clkgrp_pkg::*;
#(
    parameter int GROUP_SEL = GRP_SYSTEM,
    parameter int RIDX_W    = 2,
    parameter int DIDX_W    = 4,
    parameter int DIV_W     = 8
) (
    input  logic [RIDX_W-1:0] ridx,
    input  logic [DIDX_W-1:0] didx,
    output logic [DIV_W-1:0]  div
);
    localparam int N_RATES = grp_nrates(GROUP_SEL);
    localparam int N_DIV   = grp_ndiv(GROUP_SEL);
    localparam int N_ENT   = N_RATES * N_DIV;
    localparam int K_W     = $clog2(N_ENT);

    logic [DIV_W-1:0] tab [N_ENT];
    logic [K_W-1:0]   k;

    for (genvar d = 0; d < N_DIV; d++) begin : g_out
        for (genvar r = 0; r < N_RATES; r++) begin : g_col
            assign tab[d * N_RATES + r] = DIV_W'(grp_div(GROUP_SEL, d, r));
        end
    end

    always_comb begin
        k   = K_W'(int'(didx) * N_RATES + int'(ridx));
        div = (int'(k) < N_ENT) ? tab[k] : '0;
    end

endmodule

// File: rtl/clkgrp_rate_seq.sv
module clkgrp_rate_seq
    import clkgrp_pkg::*;
#(
    parameter int GROUP_SEL = GRP_SYSTEM,
    parameter int RATE_W    = 12,
    parameter int DIV_W     = 8,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [RATE_W-1:0] req_rate,
    input  logic [RATE_W-1:0] cur_pll_rate,
    output logic              busy,
    output logic              pll_req,
    output logic [RATE_W-1:0] pll_rate,
    input  logic              pll_ack,
    input  logic              pll_err,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DIV_W-1:0]  wr_data,
    output logic              done,
    output logic              err_rate,
    output logic              pll_fail
);
    localparam int N_RATES = grp_nrates(GROUP_SEL);
    localparam int N_DIV   = grp_ndiv(GROUP_SEL);
    localparam int RIDX_W  = (N_RATES > 1) ? $clog2(N_RATES) : 1;
    localparam int DIDX_W  = (N_DIV > 1) ? $clog2(N_DIV) : 1;
    localparam int BASE    = grp_base(GROUP_SEL);
    localparam int STRIDE  = 'h10;

    typedef struct packed {
        seq_st_e           st;
        logic [RIDX_W-1:0] ridx;
        logic [DIDX_W-1:0] didx;
        logic [RATE_W-1:0] tgt;
        logic              pre;
        logic              e_rate;
        logic              e_pll;
    } seq_t;

    seq_t q, d;

    logic              m_hit;
    logic [RIDX_W-1:0] m_ridx;
    logic [RATE_W-1:0] m_pll;
    logic [DIV_W-1:0]  rom_div;

    clkgrp_rate_match #(
        .GROUP_SEL (GROUP_SEL),
        .RATE_W    (RATE_W),
        .RIDX_W    (RIDX_W)
    ) match_i (
        .req_rate (req_rate),
        .hit      (m_hit),
        .ridx     (m_ridx),
        .pll_tgt  (m_pll)
    );

    clkgrp_div_rom #(
        .GROUP_SEL (GROUP_SEL),
        .RIDX_W    (RIDX_W),
        .DIDX_W    (DIDX_W),
        .DIV_W     (DIV_W)
    ) rom_i (
        .ridx (q.ridx),
        .didx (q.didx),
        .div  (rom_div)
    );

    always_comb begin
        d = q;
        case (q.st)
            SEQ_IDLE: begin
                if (req_valid) begin
                    d.didx  = '0;
                    d.e_pll = 1'b0;
                    if (m_hit) begin
                        d.ridx   = m_ridx;
                        d.tgt    = m_pll;
                        d.pre    = (m_pll < cur_pll_rate);
                        d.e_rate = 1'b0;
                        d.st     = (m_pll < cur_pll_rate) ? SEQ_PLL_PRE : SEQ_WRITE;
                    end else begin
                        d.e_rate = 1'b1;
                        d.st     = SEQ_FIN;
                    end
                end
            end
            SEQ_PLL_PRE: begin
                if (pll_ack) begin
                    d.e_pll = pll_err;
                    d.st    = SEQ_WRITE;
                end
            end
            SEQ_WRITE: begin
                if (q.didx == DIDX_W'(N_DIV - 1))
                    d.st = q.pre ? SEQ_FIN : SEQ_PLL_POST;
                else
                    d.didx = q.didx + 1'b1;
            end
            SEQ_PLL_POST: begin
                if (pll_ack) begin
                    d.e_pll = pll_err;
                    d.st    = SEQ_FIN;
                end
            end
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{st: SEQ_IDLE, default: '0};
        else
            q <= d;
    end

    assign busy     = (q.st != SEQ_IDLE);
    assign pll_req  = (q.st == SEQ_PLL_PRE) || (q.st == SEQ_PLL_POST);
    assign pll_rate = q.tgt;
    assign wr_en    = (q.st == SEQ_WRITE);
    assign wr_addr  = ADDR_W'(BASE) + ADDR_W'(q.didx) * ADDR_W'(STRIDE);
    assign wr_data  = rom_div;
    assign done     = (q.st == SEQ_FIN);
    assign err_rate = done & q.e_rate;
    assign pll_fail = done & q.e_pll;

    // R3: an unlisted rate ends at once with an error and no write
    assert_bad_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !m_hit) |=> (done && err_rate && !wr_en && !pll_req));

    // R6: consecutive writes step the address upward by one stride
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(STRIDE)));

    // R7: a divider value of zero is never written
    assert_div_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data != '0));

    // R8: the PLL request is held until acknowledged
    assert_pll_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_req && !pll_ack) |=> (pll_req && $stable(pll_rate)));

    // R5: a PLL request that follows writes only happens when the PLL is not slowing
    assert_post_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pll_req) && $past(wr_en)) |-> !q.pre);

    // R10: done lasts one cycle and the block then goes idle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/clkgrp_rate_seq_tb_top.sv
module clkgrp_rate_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RATE_W = 12;
    localparam int DIV_W  = 8;
    localparam int ADDR_W = 12;
    localparam int NDIV   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [RATE_W-1:0] req_rate = '0;
    logic [RATE_W-1:0] cur_pll_rate = '0;
    logic              busy, pll_req, wr_en, done, err_rate, pll_fail;
    logic [RATE_W-1:0] pll_rate;
    logic              pll_ack = 1'b0;
    logic              pll_err = 1'b0;
    logic [ADDR_W-1:0] wr_addr;
    logic [DIV_W-1:0]  wr_data;

    clkgrp_rate_seq #(.GROUP_SEL(0), .RATE_W(RATE_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rate(req_rate),
        .cur_pll_rate(cur_pll_rate), .busy(busy), .pll_req(pll_req), .pll_rate(pll_rate),
        .pll_ack(pll_ack), .pll_err(pll_err), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .err_rate(err_rate), .pll_fail(pll_fail)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor state
    int wa [32];
    int wd [32];
    int wc [32];
    int nw, pll_first, pll_tgt_s, nw_at_pll, pr_cnt, ack_cyc, done_cyc;
    bit done_seen, done_prev, err_rate_s, pll_fail_s, busy_at_done, busy_after;
    int ack_delay, wcnt;
    bit ack_errv, acked;

    always @(negedge clk) begin
        if (done_prev) busy_after = busy;
        done_prev = done;
        if (wr_en && nw < 32) begin
            wa[nw] = int'(wr_addr); wd[nw] = int'(wr_data); wc[nw] = cyc; nw++;
        end
        if (pll_req) begin
            if (pll_first < 0) begin
                pll_first = cyc; pll_tgt_s = int'(pll_rate); nw_at_pll = nw;
            end
            pr_cnt++;
        end
        if (pll_req && !acked) begin
            if (wcnt == ack_delay) begin
                pll_ack = 1'b1; pll_err = ack_errv; acked = 1'b1; ack_cyc = cyc;
            end else wcnt++;
        end else begin
            pll_ack = 1'b0; pll_err = 1'b0;
            if (!pll_req) begin acked = 1'b0; wcnt = 0; end
        end
        if (done) begin
            done_seen = 1'b1; done_cyc = cyc; err_rate_s = err_rate;
            pll_fail_s = pll_fail; busy_at_done = busy;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_idx(input int r);
        for (int i = 0; i < 4; i++) if (r == 200 * (i + 1)) return i;
        return -1;
    endfunction

    function automatic int exp_pll(input int c);
        return (c == 2) ? 600 : 800;
    endfunction

    function automatic int exp_div(input int k, input int c);
        int b [16];
        b = '{4, 0, 2, 2, 2, 2, 1, 2, 4, 2, 4, 8, 24, 4, 24, 16};
        if (k == 1) return (c == 0) ? 4 : (c == 1) ? 2 : 1;
        if (c == 2 && b[k] >= 4) return b[k] * 3 / 4;
        return b[k];
    endfunction

    task automatic run_req(input int rate, input int cur, input int delay,
                           input bit perr, input bit mid);
        int n, ei, tgt;
        bit pre;
        nw = 0; pll_first = -1; pll_tgt_s = 0; nw_at_pll = -1; pr_cnt = 0;
        ack_cyc = -1; done_seen = 0; done_cyc = -1; busy_after = 1'b1;
        cur_pll_rate = RATE_W'(cur); ack_delay = delay; ack_errv = perr;
        @(negedge clk);
        n = cyc; req_valid = 1'b1; req_rate = RATE_W'(rate);
        @(negedge clk);
        req_valid = 1'b0;
        if (mid) begin
            repeat (2) @(negedge clk);
            req_valid = 1'b1; req_rate = RATE_W'((rate == 600) ? 200 : 600);
            cur_pll_rate = RATE_W'(1000);
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int k = 0; k < 400 && !done_seen; k++) @(negedge clk);
        repeat (2) @(negedge clk);
        ei = exp_idx(rate);
        chk(done_seen, "R10", "done seen", int'(done_seen), 1);
        chk(busy_at_done && !busy_after, "R10", "busy at/after done",
            int'(busy_at_done) * 2 + int'(busy_after), 2);
        if (ei < 0) begin
            chk(done_cyc == n + 1, "R3", "done cycle", done_cyc, n + 1);
            chk(err_rate_s, "R3", "err_rate", int'(err_rate_s), 1);
            chk(nw == 0, "R3", "writes", nw, 0);
            chk(pll_first < 0, "R3", "pll_req seen", pll_first, -1);
        end else begin
            tgt = exp_pll(ei);
            pre = (tgt < cur);
            chk(!err_rate_s, "R9", "err_rate", int'(err_rate_s), 0);
            chk(pll_fail_s == perr, "R9", "pll_fail", int'(pll_fail_s), int'(perr));
            chk(pll_tgt_s == tgt, "R2", "pll target", pll_tgt_s, tgt);
            chk(pr_cnt == delay + 1, "R8", "pll_req cycles", pr_cnt, delay + 1);
            chk(nw == NDIV, "R6", "write count", nw, NDIV);
            if (nw == NDIV) begin
                for (int k = 0; k < NDIV; k++) begin
                    chk(wa[k] == 'h180 + 'h10 * k, "R6", "address", wa[k], 'h180 + 'h10 * k);
                    chk(wd[k] == exp_div(k, ei), "R7", "divider", wd[k], exp_div(k, ei));
                    chk(wc[k] == wc[0] + k, "R6", "write cycle", wc[k], wc[0] + k);
                end
                if (pre) begin
                    chk(pll_first == n + 1, "R4", "pll_req start", pll_first, n + 1);
                    chk(nw_at_pll == 0, "R4", "writes before pll", nw_at_pll, 0);
                    chk(wc[0] == ack_cyc + 1, "R4", "first write", wc[0], ack_cyc + 1);
                    chk(done_cyc == wc[NDIV-1] + 1, "R10", "done cycle", done_cyc, wc[NDIV-1] + 1);
                end else begin
                    chk(wc[0] == n + 1, "R5", "first write", wc[0], n + 1);
                    chk(pll_first == wc[NDIV-1] + 1, "R5", "pll_req start",
                        pll_first, wc[NDIV-1] + 1);
                    chk(nw_at_pll == NDIV, "R5", "writes before pll", nw_at_pll, NDIV);
                    chk(done_cyc == ack_cyc + 1, "R10", "done cycle", done_cyc, ack_cyc + 1);
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rates [4];
        int r, c;
        rates = '{200, 400, 600, 800};
        void'($urandom(32'd20240611));
        nw = 0; pll_first = -1; acked = 1'b0; wcnt = 0; ack_delay = 0;
        done_prev = 1'b0; done_seen = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err_rate && !pll_fail && !wr_en && !pll_req, "R1",
            "idle outputs under reset", int'(busy || done || wr_en || pll_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !wr_en && !pll_req, "R1", "idle outputs after reset",
            int'(busy || done || wr_en || pll_req), 0);

        // directed: every rate with current above, equal and below the target
        foreach (rates[i]) begin
            run_req(rates[i], exp_pll(i) + 100, 2, 1'b0, 1'b0);   // R4 pre order
            run_req(rates[i], exp_pll(i), 0, 1'b0, 1'b0);         // R5 tie goes post
            run_req(rates[i], exp_pll(i) - 100, 3, 1'b1, 1'b0);   // R5, R9 failure
        end
        run_req(0, 800, 0, 1'b0, 1'b0);      // R3
        run_req(201, 800, 0, 1'b0, 1'b0);    // R3 near miss
        run_req(799, 800, 0, 1'b0, 1'b0);    // R3 near miss
        run_req(400, 900, 4, 1'b0, 1'b1);    // R11 pre order, second request mid-run
        run_req(600, 500, 1, 1'b0, 1'b1);    // R11 post order, second request mid-run

        for (int t = 0; t < 60; t++) begin
            r = ($urandom % 4 != 0) ? rates[$urandom % 4] : int'($urandom % 1024);
            case ($urandom % 4)
                0: c = 600;
                1: c = 700;
                2: c = 800;
                default: c = 100 + int'($urandom % 1000);
            endcase
            run_req(r, c, int'($urandom % 6), ($urandom % 4) == 0, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule